// File: doc/BRIEF.md
# Fragmented frame FIFO space checker

This block watches the buffer descriptors that make up one outgoing frame and works out how many bytes that frame will take in a store-and-forward transmit FIFO. Each descriptor carries a byte offset inside the first 32-bit word, a byte length, and flags that mark the opening and closing segments. A buffer costs every word it touches, from the partially used first word to the partially used last word. Whole-word alignment and command words cost nothing. A buffer's cost is therefore 4 × ceil((offset + length) / 4) bytes.

When the closing descriptor arrives, the block emits a one-cycle result. The result holds the frame's total byte cost and three verdicts. The first says whether the frame fits a fixed budget (2,036 bytes by default). The second says whether it has more buffers than a conservative fragment limit (86 by default). The third says whether any middle buffer was shorter than the minimum length (4 bytes). The driver uses the first two verdicts to decide whether the frame must be copied into one contiguous buffer before it is sent.

Descriptors enter on a valid/ready stream. Ready is low during reset and high from the first clock after it, so back-pressure never occurs in operation. A descriptor is taken on any clock edge where valid and ready are both high. The result and sequence-error outputs are plain one-cycle pulses with no back-pressure.

Top module: `frag_space_checker`

## Requirements
- R1: `desc_ready` is 0 while `rst_n` is low and 1 from the first clock after reset. In reset, `res_valid` and `seq_err` are 0.
- R2: A buffer with offset o (0 to 3) and length L costs 4 × ceil((o + L) / 4) bytes. A zero-length buffer at offset 0 costs 0 bytes.
- R3: One cycle after the closing descriptor (`desc_last` = 1) of an open frame is taken, `res_valid` is 1 for exactly one cycle. `res_bytes` then equals the sum of the costs of all the frame's buffers.
- R4: A descriptor with `desc_first` = 1 starts a new frame and discards any partial sums, even when a frame is already open. A descriptor with both flags set is a complete frame on its own.
- R5: `res_fits` is 1 exactly when `res_bytes` ≤ BUDGET. The limit is inclusive: 2036 fits and 2040 does not.
- R6: `res_too_frag` is 1 exactly when the frame has more than FRAG_LIMIT buffers. 86 buffers give 0 and 87 give 1.
- R7: `res_rule_viol` is 1 when any buffer with both flags clear has a length below 4. A short first or last buffer does not set it.
- R8: A descriptor with `desc_first` = 0 that is taken while no frame is open gives a one-cycle `seq_err` pulse on the next cycle. No result is produced for it, and the descriptor does not affect any later frame.
- R9: The byte total saturates at 2^ACC_W − 1 instead of wrapping, so an oversized frame always reports `res_fits` = 0.
- R10: A frame closes after its last descriptor. A following descriptor without `desc_first` is a sequence error (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Descriptor accepted when high with valid |
| desc_offset | input | 2 | Byte offset inside the first word |
| desc_len | input | LEN_W (16) | Buffer length in bytes |
| desc_first | input | 1 | Opening segment of a frame |
| desc_last | input | 1 | Closing segment of a frame |
| res_valid | output | 1 | One-cycle result pulse |
| res_bytes | output | ACC_W (16) | Saturated byte cost of the frame |
| res_fits | output | 1 | Frame fits the budget |
| res_too_frag | output | 1 | Buffer count above limit |
| res_rule_viol | output | 1 | Short middle buffer seen |
| seq_err | output | 1 | One-cycle pulse for an orphan descriptor |

## Verification
Two functions can fall on the same descriptor. A descriptor carrying both flags restarts the sums and also closes the frame in the same cycle. The bench sends it straight after an open frame that already holds a large partial sum, and accepts the result only if `res_bytes` equals that one buffer's cost. Saturation and the final verdict also meet in one cycle: a closing descriptor pushes the sum past the counter range, and the bench expects a clamped total together with `res_fits` = 0. Descriptors are driven back to back with no idle cycles, so every per-cycle update path is exercised on consecutive edges.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int WORD_BYTES = 4;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 1;
    while ((1 << r) <= v) r++;
    return r;
  endfunction
endpackage

// File: rtl/fsc_span_calc.sv
module fsc_span_calc #(
  parameter int LEN_W = 16,
  localparam int SPAN_W = LEN_W + 2
) (
  input  logic [1:0]        offset,
  input  logic [LEN_W-1:0]  len,
  output logic [SPAN_W-1:0] span
);
  logic [SPAN_W-1:0] end_pos;
  logic [SPAN_W-1:0] rounded;

  always_comb begin
    end_pos = SPAN_W'(len) + SPAN_W'(offset);
    rounded = end_pos + SPAN_W'(fsc_pkg::WORD_BYTES - 1);
    span    = {rounded[SPAN_W-1:2], 2'b00};
  end
endmodule

// File: rtl/fsc_sat_add.sv
module fsc_sat_add #(
  parameter int A_W = 16,
  parameter int B_W = 18
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [A_W-1:0] y
);
  localparam int S_W = ((A_W > B_W) ? A_W : B_W) + 1;
  localparam logic [S_W-1:0] LIMIT = S_W'({A_W{1'b1}});

  logic [S_W-1:0] s;

  always_comb begin
    s = S_W'(a) + S_W'(b);
    y = (s > LIMIT) ? {A_W{1'b1}} : s[A_W-1:0];
  end
endmodule

// File: rtl/fsc_frame_ctrl.sv
module fsc_frame_ctrl #(
  parameter int LEN_W      = 16,
  parameter int ACC_W      = 16,
  parameter int CNT_W      = 8,
  parameter int BUDGET     = 2036,
  parameter int FRAG_LIMIT = 86,
  parameter int MIN_MID    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  input  logic [ACC_W-1:0] sum_new,
  output logic [ACC_W-1:0] acc_base,
  output logic             ready,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_bytes,
  output logic             res_fits,
  output logic             res_too_frag,
  output logic             res_rule_viol,
  output logic             seq_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic {S_IDLE, S_OPEN} state_t;

  state_t           state_q;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             viol_q;

  logic             live;
  logic             orphan;
  logic             mid_short;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_new;
  logic             viol_new;

  always_comb begin
    live      = take && (first || state_q == S_OPEN);
    orphan    = take && !first && state_q == S_IDLE;
    mid_short = !first && !last && (len < LEN_W'(MIN_MID));
    acc_base  = first ? '0 : acc_q;
    cnt_base  = first ? '0 : cnt_q;
    cnt_new   = (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
    viol_new  = (first ? 1'b0 : viol_q) | mid_short;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      acc_q         <= '0;
      cnt_q         <= '0;
      viol_q        <= 1'b0;
      ready         <= 1'b0;
      res_valid     <= 1'b0;
      res_bytes     <= '0;
      res_fits      <= 1'b0;
      res_too_frag  <= 1'b0;
      res_rule_viol <= 1'b0;
      seq_err       <= 1'b0;
    end else begin
      ready     <= 1'b1;
      res_valid <= 1'b0;
      seq_err   <= orphan;
      if (live) begin
        if (last) begin
          state_q       <= S_IDLE;
          res_valid     <= 1'b1;
          res_bytes     <= sum_new;
          res_fits      <= (sum_new <= ACC_W'(BUDGET));
          res_too_frag  <= (cnt_new > CNT_W'(FRAG_LIMIT));
          res_rule_viol <= viol_new;
        end else begin
          state_q <= S_OPEN;
          acc_q   <= sum_new;
          cnt_q   <= cnt_new;
          viol_q  <= viol_new;
        end
      end
    end
  end
endmodule

// File: rtl/frag_space_checker.sv
module frag_space_checker #(
  parameter int LEN_W      = 16,
  parameter int ACC_W      = 16,
  parameter int BUDGET     = 2036,
  parameter int FRAG_LIMIT = 86,
  parameter int MIN_MID    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [1:0]       desc_offset,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_first,
  input  logic             desc_last,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_bytes,
  output logic             res_fits,
  output logic             res_too_frag,
  output logic             res_rule_viol,
  output logic             seq_err
);
  localparam int SPAN_W = LEN_W + 2;
  localparam int CNT_W  = fsc_pkg::clog2_min1(FRAG_LIMIT + 1) + 1;

  logic [SPAN_W-1:0] span;
  logic [ACC_W-1:0]  acc_base;
  logic [ACC_W-1:0]  sum_new;
  logic              take;

  assign take = desc_valid && desc_ready;

  fsc_span_calc #(.LEN_W(LEN_W)) u_span (
    .offset (desc_offset),
    .len    (desc_len),
    .span   (span)
  );

  fsc_sat_add #(.A_W(ACC_W), .B_W(SPAN_W)) u_add (
    .a (acc_base),
    .b (span),
    .y (sum_new)
  );

  fsc_frame_ctrl #(
    .LEN_W(LEN_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
    .BUDGET(BUDGET), .FRAG_LIMIT(FRAG_LIMIT), .MIN_MID(MIN_MID)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .first         (desc_first),
    .last          (desc_last),
    .len           (desc_len),
    .sum_new       (sum_new),
    .acc_base      (acc_base),
    .ready         (desc_ready),
    .res_valid     (res_valid),
    .res_bytes     (res_bytes),
    .res_fits      (res_fits),
    .res_too_frag  (res_too_frag),
    .res_rule_viol (res_rule_viol),
    .seq_err       (seq_err)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int LEN_W  = 16,
  parameter int ACC_W  = 16,
  parameter int BUDGET = 2036
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic             desc_first,
  input logic             desc_last,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_bytes,
  input logic             res_fits,
  input logic             seq_err
);
  a_r1_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> desc_ready);

  a_r3_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(desc_valid && desc_ready && desc_last));

  a_r5_fits_matches_total: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fits == (res_bytes <= ACC_W'(BUDGET))));

  a_r8_orphan_source: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(desc_valid && desc_ready && !desc_first));

  a_r8_no_result_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && seq_err));

  a_r9_saturated_never_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_bytes == {ACC_W{1'b1}} && BUDGET < (1 << ACC_W) - 1) |-> !res_fits);
endmodule

bind frag_space_checker fsc_checker #(.LEN_W(LEN_W), .ACC_W(ACC_W), .BUDGET(BUDGET)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_first (desc_first),
  .desc_last  (desc_last),
  .res_valid  (res_valid),
  .res_bytes  (res_bytes),
  .res_fits   (res_fits),
  .seq_err    (seq_err)
);

// File: tb/frag_space_checker_tb.sv
module frag_space_checker_tb;
  localparam int LEN_W = 16;
  localparam int ACC_W = 16;
  localparam int SAT   = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic desc_ready;
  logic [1:0] desc_offset = '0;
  logic [LEN_W-1:0] desc_len = '0;
  logic desc_first = 1'b0;
  logic desc_last = 1'b0;
  logic res_valid;
  logic [ACC_W-1:0] res_bytes;
  logic res_fits, res_too_frag, res_rule_viol, seq_err;

  always #5 clk = ~clk;

  frag_space_checker u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_offset(desc_offset), .desc_len(desc_len), .desc_first(desc_first),
    .desc_last(desc_last), .res_valid(res_valid), .res_bytes(res_bytes),
    .res_fits(res_fits), .res_too_frag(res_too_frag),
    .res_rule_viol(res_rule_viol), .seq_err(seq_err)
  );

  typedef struct {
    bit    is_err;
    int    bytes;
    bit    fits;
    bit    frag;
    bit    viol;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  bit m_open = 0;
  int m_acc  = 0;
  int m_cnt  = 0;
  bit m_viol = 0;
  string cur_req = "R3";

  function automatic int cost(int off, int len);
    return ((off + len + 3) / 4) * 4;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(int off, int len, bit first, bit last);
    exp_t e;
    @(negedge clk);
    desc_valid  = 1'b1;
    desc_offset = off[1:0];
    desc_len    = len[LEN_W-1:0];
    desc_first  = first;
    desc_last   = last;
    if (!first && !m_open) begin
      e = '{1, 0, 0, 0, 0, cur_req};
      exp_q.push_back(e);
    end else begin
      if (first) begin m_acc = 0; m_cnt = 0; m_viol = 0; end
      m_acc = m_acc + cost(off, len);
      if (m_acc > SAT) m_acc = SAT;
      m_cnt++;
      if (!first && !last && len < 4) m_viol = 1;
      if (last) begin
        e = '{0, m_acc, (m_acc <= 2036), (m_cnt > 86), m_viol, cur_req};
        exp_q.push_back(e);
        m_open = 0;
      end else m_open = 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      desc_valid = 1'b0;
    end
  endtask

  // Monitor: outputs are registered, so a descriptor taken at edge k shows here at the next negedge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (res_valid || seq_err)) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected output pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_err) begin
            check(seq_err && !res_valid, e.req, "seq_err pulse", int'(seq_err), 1);
          end else begin
            check(res_valid && !seq_err, e.req, "res_valid", int'(res_valid), 1);
            check(int'(res_bytes) == e.bytes, e.req, "res_bytes", int'(res_bytes), e.bytes);
            check(res_fits == e.fits, "R5", "res_fits", int'(res_fits), int'(e.fits));
            check(res_too_frag == e.frag, "R6", "res_too_frag", int'(res_too_frag), int'(e.frag));
            check(res_rule_viol == e.viol, "R7", "res_rule_viol", int'(res_rule_viol), int'(e.viol));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(desc_ready == 1'b0, "R1", "ready in reset", int'(desc_ready), 0);
    check(res_valid == 1'b0 && seq_err == 1'b0, "R1", "pulses in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(desc_ready == 1'b1, "R1", "ready after reset", int'(desc_ready), 1);

    cur_req = "R2"; send(0, 64, 1, 1);
    send(0, 0, 1, 1);
    cur_req = "R3"; send(1, 60, 1, 0); send(3, 4, 0, 0); send(2, 3, 0, 1);
    cur_req = "R7"; send(0, 1, 1, 0); send(0, 8, 0, 0); send(0, 1, 0, 1);
    send(0, 8, 1, 0); send(1, 3, 0, 0); send(0, 8, 0, 1);
    cur_req = "R5"; send(0, 2036, 1, 1); send(1, 2035, 1, 1); send(0, 2037, 1, 1);
    cur_req = "R6";
    for (int i = 0; i < 86; i++) send(0, 8, i == 0, i == 85);
    for (int i = 0; i < 87; i++) send(0, 8, i == 0, i == 86);
    cur_req = "R4"; send(0, 1500, 1, 0); send(3, 5, 1, 1);
    send(0, 900, 1, 0); send(0, 100, 1, 0); send(0, 20, 0, 1);
    cur_req = "R9"; send(0, 40000, 1, 0); send(0, 40000, 0, 1);
    cur_req = "R8"; send(0, 8, 0, 1); send(0, 8, 0, 0);
    cur_req = "R8"; send(0, 16, 1, 1);
    cur_req = "R10"; send(0, 4, 1, 1); send(0, 4, 0, 0);
    cur_req = "R10"; send(2, 2, 1, 1);
    idle(5);
    check(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule